// File: doc/BRIEF.md
# Seconds Clock Register Core with Pulse-Gated Transfers

This block keeps wall time in seconds as the sum of a 32-bit base and a free-running 32-bit seconds counter. A 1 Hz tick input advances the counter. Software writes and reads the state through 16-bit host registers. Software does not touch the base, the counter or the two flags directly. Instead it sets request bits in a control word. Each request takes effect only on the cycle when the isolation pulse input is high. The logic that makes that pulse, and the prescaler that makes the tick, sit outside this block.

To set the time, software does three steps. It loads the write-data registers and requests a base write. It then requests a counter clear. Last, it writes the valid flag as 1. A reader first checks that the valid flag reads back as 1, then fetches the base through the read-data registers. The counter comes back in two stages. The first stage copies the counter into a hidden staging register on a pulse. The second stage is a 1-to-0 transition of the trigger bit, which copies the staged value into the counter-read registers. The sum of base and counter also appears on an output port, together with the valid flag.

Top module: `rtc_regcore`

## Requirements
- R1: After reset, base, counter, both flags, read-data, staging and counter-read values are zero, every host register reads zero, `time_sec` is 0 and `time_valid` is 0.
- R2: Host writes (byte address on `reg_addr`) land in the control word 0x00, the prepare word 0x04, write-data low 0x10 and high 0x14, and the trigger word 0x38, and each reads back as written. Read-data low 0x24 and high 0x28 and counter-read low 0x30 and high 0x34 are read-only: writes to them are ignored. Unmapped addresses read 0. A 32-bit value always puts bits 15:0 in the low word and bits 31:16 in the high word.
- R3: No base, flag or read-data change and no counter clear happens in a cycle without `iso_pulse`, whatever request bits are set.
- R4: With control bit 1 set at a pulse, the base becomes {write-data high, write-data low}.
- R5: At a pulse, read requests load read-data. Control bit 2 loads the base. Bit 7 loads the valid flag, zero-extended. Bit 8 loads the spare flag, zero-extended. If more than one is set, the order of preference is base, then valid flag, then spare flag. With no read request, read-data holds.
- R6: At a pulse, control bit 5 loads the valid flag and bit 6 loads the spare flag, each from write-data bit 0.
- R7: The counter adds 1 in every cycle with `tick_1hz` high and wraps modulo 2^32. Control bit 3 at a pulse clears the counter to 0, and this clear wins over a tick in the same cycle.
- R8: With prepare bit 0 set at a pulse, the staging register takes the counter value after any clear of that pulse and before that cycle's tick. A host write to the trigger word that takes bit 0 from 1 to 0 copies the staged value into counter-read low/high.
- R9: `time_sec` equals base plus counter modulo 2^32, and `time_valid` equals the valid flag.
- R10: When several requests share one pulse, they apply in order: counter clear first, then writes, then reads. A read therefore returns a value written at the same pulse, and staging returns 0 when the clear shares the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle seconds tick |
| iso_pulse | input | 1 | Commit strobe for posted requests |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 6 | Host byte address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for `reg_addr` (combinational) |
| time_sec | output | 32 | Base plus counter |
| time_valid | output | 1 | Valid flag |

## Verification
The bench aims at pulses that carry several requests at once. A core that applied reads before writes would return the stale base. A core that let a tick beat a clear would leave the counter at 1. The bench also sets every request bit and then withholds the pulse, to catch a core that acts on the request bits by level alone. It checks that a trigger write of 1 on its own, or of 0 with no prior 1, leaves the counter-read words unchanged, to catch a latch on the wrong edge. Last, a base near the top of the range plus a few dozen ticks exposes a time sum that saturates or keeps a carry, where a correct sum wraps.

// File: rtl/rtc_regcore_pkg.sv
package rtc_regcore_pkg;

  localparam int REG_W = 16;
  localparam int VAL_W = 32;
  localparam int ADR_W = 6;

  // host word byte offsets
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_PREP = 'h04;
  localparam int OFS_WDL  = 'h10;
  localparam int OFS_RDL  = 'h24;
  localparam int OFS_CNTL = 'h30;
  localparam int OFS_TRIG = 'h38;
  localparam int HALF_STRIDE = 4;

  // control word request bit positions
  localparam int CB_BASE_WR = 1;
  localparam int CB_BASE_RD = 2;
  localparam int CB_CNT_CLR = 3;
  localparam int CB_F0_WR   = 5;
  localparam int CB_F1_WR   = 6;
  localparam int CB_F0_RD   = 7;
  localparam int CB_F1_RD   = 8;

  typedef struct packed {
    logic base_wr;
    logic base_rd;
    logic cnt_clr;
    logic f0_wr;
    logic f1_wr;
    logic f0_rd;
    logic f1_rd;
  } req_t;

  typedef enum logic [1:0] {RD_NONE, RD_BASE, RD_F0, RD_F1} rdsel_e;

  function automatic req_t decode_req(input logic [REG_W-1:0] c);
    req_t r;
    r.base_wr = c[CB_BASE_WR];
    r.base_rd = c[CB_BASE_RD];
    r.cnt_clr = c[CB_CNT_CLR];
    r.f0_wr   = c[CB_F0_WR];
    r.f1_wr   = c[CB_F1_WR];
    r.f0_rd   = c[CB_F0_RD];
    r.f1_rd   = c[CB_F1_RD];
    return r;
  endfunction

  // preference among simultaneous read requests
  function automatic rdsel_e pick_read(input req_t r);
    if (r.base_rd)    return RD_BASE;
    else if (r.f0_rd) return RD_F0;
    else if (r.f1_rd) return RD_F1;
    else              return RD_NONE;
  endfunction

  // counter after the clear step of a pulse (before this cycle's tick)
  function automatic logic [VAL_W-1:0] after_clear(input logic [VAL_W-1:0] cnt,
                                                   input logic clr);
    return clr ? '0 : cnt;
  endfunction

endpackage

// File: rtl/rtc_hostregs.sv
module rtc_hostregs
  import rtc_regcore_pkg::*;
#(
  parameter int AW = ADR_W,
  parameter int DW = REG_W,
  parameter int VW = VAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [VW-1:0] rd_val,
  input  logic [VW-1:0] cnt_val,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctl_word,
  output logic          prep_bit,
  output logic [VW-1:0] wr_val,
  output logic          trig_fall
);
  localparam int NH = VW / DW;

  logic [DW-1:0] ctl_q, prep_q, trig_q;
  logic [DW-1:0] wd_q [NH];

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      prep_q <= '0;
      trig_q <= '0;
    end else if (wr_en) begin
      if (hit(addr, OFS_CTL))  ctl_q  <= wdata;
      if (hit(addr, OFS_PREP)) prep_q <= wdata;
      if (hit(addr, OFS_TRIG)) trig_q <= wdata;
    end
  end

  genvar h;
  generate
    for (h = 0; h < NH; h++) begin : g_wd
      always_ff @(posedge clk) begin
        if (!rst_n)
          wd_q[h] <= '0;
        else if (wr_en && hit(addr, OFS_WDL + HALF_STRIDE*h))
          wd_q[h] <= wdata;
      end
      assign wr_val[h*DW +: DW] = wd_q[h];
    end
  endgenerate

  assign trig_fall = wr_en && hit(addr, OFS_TRIG) && trig_q[0] && !wdata[0];
  assign ctl_word  = ctl_q;
  assign prep_bit  = prep_q[0];

  always_comb begin
    rdata = '0;
    if (hit(addr, OFS_CTL))  rdata = ctl_q;
    if (hit(addr, OFS_PREP)) rdata = prep_q;
    if (hit(addr, OFS_TRIG)) rdata = trig_q;
    for (int k = 0; k < NH; k++) begin
      if (hit(addr, OFS_WDL  + HALF_STRIDE*k)) rdata = wd_q[k];
      if (hit(addr, OFS_RDL  + HALF_STRIDE*k)) rdata = rd_val[k*DW +: DW];
      if (hit(addr, OFS_CNTL + HALF_STRIDE*k)) rdata = cnt_val[k*DW +: DW];
    end
  end

endmodule

// File: rtl/rtc_seccount.sv
module rtc_seccount #(
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  output logic [VW-1:0] cnt
);
  logic [VW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + {{(VW-1){1'b0}}, 1'b1};
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rtc_statecore.sv
module rtc_statecore
  import rtc_regcore_pkg::*;
#(
  parameter int VW = VAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse,
  input  req_t          req,
  input  logic          prep,
  input  logic [VW-1:0] wr_val,
  input  logic [VW-1:0] cnt,
  output logic [VW-1:0] base,
  output logic          flag0,
  output logic          flag1,
  output logic [VW-1:0] rd_val,
  output logic [VW-1:0] stage
);
  logic [VW-1:0] base_q, rd_q, stage_q;
  logic          f0_q, f1_q;
  logic [VW-1:0] base_n;
  logic          f0_n, f1_n;
  rdsel_e        sel;

  // write step: values after this pulse's writes
  always_comb begin
    base_n = (pulse && req.base_wr) ? wr_val    : base_q;
    f0_n   = (pulse && req.f0_wr)   ? wr_val[0] : f0_q;
    f1_n   = (pulse && req.f1_wr)   ? wr_val[0] : f1_q;
    sel    = pick_read(req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      f0_q    <= 1'b0;
      f1_q    <= 1'b0;
      rd_q    <= '0;
      stage_q <= '0;
    end else begin
      base_q <= base_n;
      f0_q   <= f0_n;
      f1_q   <= f1_n;
      if (pulse) begin
        case (sel)
          RD_BASE: rd_q <= base_n;
          RD_F0:   rd_q <= {{(VW-1){1'b0}}, f0_n};
          RD_F1:   rd_q <= {{(VW-1){1'b0}}, f1_n};
          default: rd_q <= rd_q;
        endcase
        if (prep) stage_q <= after_clear(cnt, req.cnt_clr);
      end
    end
  end

  assign base   = base_q;
  assign flag0  = f0_q;
  assign flag1  = f1_q;
  assign rd_val = rd_q;
  assign stage  = stage_q;
endmodule

// File: rtl/rtc_snaplatch.sv
module rtc_snaplatch #(
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [VW-1:0] stage,
  output logic [VW-1:0] snap
);
  logic [VW-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    snap_q <= '0;
    else if (load) snap_q <= stage;
  end

  assign snap = snap_q;
endmodule

// File: rtl/rtc_regcore.sv
module rtc_regcore
  import rtc_regcore_pkg::*;
#(
  parameter int AW = ADR_W,
  parameter int DW = REG_W,
  parameter int VW = VAL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_1hz,
  input  logic          iso_pulse,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [VW-1:0] time_sec,
  output logic          time_valid
);
  // named internal events, observed by the bound checker
  logic [DW-1:0] ctl_word;
  req_t          req_w;
  logic          prep_w;
  logic [VW-1:0] wr_val_w;
  logic          trig_fall_w;
  logic          cnt_clr_w;
  logic [VW-1:0] cnt_w, base_w, rd_val_w, stage_w, snap_w;
  logic          flag0_w, flag1_w;

  rtc_hostregs #(.AW(AW), .DW(DW), .VW(VW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rd_val   (rd_val_w),
    .cnt_val  (snap_w),
    .rdata    (reg_rdata),
    .ctl_word (ctl_word),
    .prep_bit (prep_w),
    .wr_val   (wr_val_w),
    .trig_fall(trig_fall_w)
  );

  assign req_w     = decode_req(ctl_word);
  assign cnt_clr_w = iso_pulse && req_w.cnt_clr;

  rtc_seccount #(.VW(VW)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1hz),
    .clr  (cnt_clr_w),
    .cnt  (cnt_w)
  );

  rtc_statecore #(.VW(VW)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (iso_pulse),
    .req   (req_w),
    .prep  (prep_w),
    .wr_val(wr_val_w),
    .cnt   (cnt_w),
    .base  (base_w),
    .flag0 (flag0_w),
    .flag1 (flag1_w),
    .rd_val(rd_val_w),
    .stage (stage_w)
  );

  rtc_snaplatch #(.VW(VW)) u_snap (
    .clk  (clk),
    .rst_n(rst_n),
    .load (trig_fall_w),
    .stage(stage_w),
    .snap (snap_w)
  );

  // modular sum: the carry out of the top bit is dropped
  assign time_sec   = base_w + cnt_w;
  assign time_valid = flag0_w;

endmodule

// File: rtl/rtc_regcore_chk.sv
module rtc_regcore_chk #(
  parameter int VW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iso_pulse,
  input logic          tick,
  input logic          clr_req,
  input logic          trig_fall,
  input logic [VW-1:0] base,
  input logic [VW-1:0] cnt,
  input logic [VW-1:0] rd_val,
  input logic [VW-1:0] stage,
  input logic [VW-1:0] snap,
  input logic          flag0
);
  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_pulse |=> $stable(base));
  // R3
  rdval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_pulse |=> $stable(rd_val));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_pulse |=> $stable(flag0));
  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_pulse && clr_req) |=> cnt == '0);
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iso_pulse && clr_req) && tick) |=> cnt == $past(cnt) + {{(VW-1){1'b0}}, 1'b1});
  // R7
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(iso_pulse && clr_req) && !tick) |=> $stable(cnt));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_fall |=> $stable(snap));
  // R8
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fall |=> snap == $past(stage));
endmodule

bind rtc_regcore rtc_regcore_chk #(.VW(VW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iso_pulse(iso_pulse),
  .tick     (tick_1hz),
  .clr_req  (req_w.cnt_clr),
  .trig_fall(trig_fall_w),
  .base     (base_w),
  .cnt      (cnt_w),
  .rd_val   (rd_val_w),
  .stage    (stage_w),
  .snap     (snap_w),
  .flag0    (flag0_w)
);

// File: tb/tb_rtc_regcore.sv
`timescale 1ns/1ps
module tb_rtc_regcore;
  localparam int CLK_NS = 20;
  localparam logic [5:0] A_CTL = 6'h00, A_PREP = 6'h04, A_WDL = 6'h10, A_WDH = 6'h14,
                         A_RDL = 6'h24, A_RDH = 6'h28, A_CNL = 6'h30, A_CNH = 6'h34,
                         A_TRIG = 6'h38;
  localparam logic [15:0] M_BWR = 16'h0002, M_BRD = 16'h0004, M_CLR = 16'h0008,
                          M_F0W = 16'h0020, M_F1W = 16'h0040, M_F0R = 16'h0080,
                          M_F1R = 16'h0100, M_ALL = 16'h01EE;

  logic clk = 0, rst_n = 0, tick_1hz = 0, iso_pulse = 0, reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [31:0] time_sec;
  logic        time_valid;

  int nchk = 0, nfail = 0;
  logic done = 0;

  // reference model
  logic [31:0] m_base, m_cnt, m_rd, m_stage, m_snap, m_wd;
  logic        m_f0, m_f1;

  rtc_regcore dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic rd32(input logic [5:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l); rd(lo + 6'h4, h); v = {h, l};
  endtask

  task automatic set_wd(input logic [31:0] v);
    wr(A_WDL, v[15:0]); wr(A_WDH, v[31:16]); m_wd = v;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
      m_cnt = m_cnt + 1;
    end
  endtask

  function automatic logic [31:0] zx(input logic b);
    return {31'b0, b};
  endfunction

  // model of one pulse: clear, then writes, then reads
  task automatic model_pulse(input logic [15:0] c, input logic p, input logic t);
    logic [31:0] cnt_c;
    cnt_c = c[3] ? 32'h0 : m_cnt;
    if (p) m_stage = cnt_c;
    m_cnt = c[3] ? 32'h0 : cnt_c + zx(t);
    if (c[1]) m_base = m_wd;
    if (c[5]) m_f0 = m_wd[0];
    if (c[6]) m_f1 = m_wd[0];
    if (c[2])      m_rd = m_base;
    else if (c[7]) m_rd = zx(m_f0);
    else if (c[8]) m_rd = zx(m_f1);
  endtask

  task automatic op(input logic [15:0] c, input logic p, input logic t);
    wr(A_CTL, c); wr(A_PREP, {15'b0, p});
    @(negedge clk); iso_pulse = 1; tick_1hz = t;
    @(negedge clk); iso_pulse = 0; tick_1hz = 0;
    model_pulse(c, p, t);
    wr(A_CTL, 16'h0); wr(A_PREP, 16'h0);
  endtask

  task automatic latch_cnt();
    wr(A_TRIG, 16'h1); wr(A_TRIG, 16'h0); m_snap = m_stage;
  endtask

  task automatic verify(input string tag);
    logic [31:0] v;
    rd32(A_RDL, v); chk({tag, " rdata"}, v, m_rd);
    rd32(A_CNL, v); chk({tag, " cntread"}, v, m_snap);
    #1;
    chk({tag, " time"}, time_sec, m_base + m_cnt);
    chk({tag, " valid"}, zx(time_valid), zx(m_f0));
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_base = 0; m_cnt = 0; m_rd = 0; m_stage = 0; m_snap = 0; m_wd = 0; m_f0 = 0; m_f1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(6'(a), d); chk("R1 reg reset", {16'h0, d}, 32'h0);
    end
    verify("R1");

    // R2: map, readback, read-only words, unmapped
    set_wd(32'h5A5AC3C3);
    rd(A_WDL, d); chk("R2 wdl readback", {16'h0, d}, 32'hC3C3);
    rd(A_WDH, d); chk("R2 wdh readback", {16'h0, d}, 32'h5A5A);
    wr(A_RDL, 16'hFFFF); wr(A_CNH, 16'hFFFF);
    rd(A_RDL, d); chk("R2 rdata read-only", {16'h0, d}, 32'h0);
    rd(A_CNH, d); chk("R2 cnt read-only", {16'h0, d}, 32'h0);
    wr(6'h08, 16'h1234); rd(6'h08, d); chk("R2 unmapped", {16'h0, d}, 32'h0);
    wr(A_TRIG, 16'h0006); rd(A_TRIG, d); chk("R2 trig readback", {16'h0, d}, 32'h0006);
    wr(A_TRIG, 16'h0);

    // R3: every request set, no pulse
    wr(A_CTL, M_ALL); wr(A_PREP, 16'h1);
    rd(A_CTL, d); chk("R2 ctl readback", {16'h0, d}, {16'h0, M_ALL});
    repeat (5) @(negedge clk);
    wr(A_CTL, 16'h0); wr(A_PREP, 16'h0);
    verify("R3 no pulse");

    // R4 R6 R7: set-time sequence
    ticks(3);
    set_wd(32'h12345678); op(M_BWR, 0, 0);
    op(M_CLR, 0, 0);
    set_wd(32'h1); op(M_F0W, 0, 0);
    verify("R4 R6 set time");
    chk("R9 time after set", time_sec, 32'h12345678);

    // R5: reads and their preference
    op(M_F0R, 0, 0); verify("R5 flag0 read"); chk("R5 flag0 value", m_rd, 32'h1);
    op(M_F1R, 0, 0); verify("R5 flag1 read");
    op(M_F1R | M_F0R | M_BRD, 0, 0); verify("R5 base wins");
    op(M_F1R | M_F0R, 0, 0); verify("R5 flag0 beats flag1");

    // R7 R8: ticks then two-stage counter read
    ticks(5);
    op(16'h0, 1, 0);
    rd32(A_CNL, v); chk("R8 stage not yet visible", v, 32'h0);
    wr(A_TRIG, 16'h1); rd32(A_CNL, v); chk("R8 set alone no latch", v, 32'h0);
    wr(A_TRIG, 16'h0); m_snap = m_stage;
    rd32(A_CNL, v); chk("R8 counter latched", v, 32'd5);
    wr(A_TRIG, 16'h0); rd32(A_CNL, v); chk("R8 0 to 0 no latch", v, 32'd5);

    // R7: clear beats a same-cycle tick
    op(M_CLR, 0, 1); verify("R7 clear vs tick");
    op(16'h0, 0, 1); verify("R7 tick at idle pulse");

    // R9: sum wraps
    set_wd(32'hFFFFFFF0); op(M_BWR | M_CLR, 0, 0);
    ticks(32);
    chk("R9 wrap", time_sec, 32'h00000010);

    // R10: write then read in one pulse; clear then stage in one pulse
    set_wd(32'hABCD0123); op(M_BWR | M_BRD, 0, 0);
    chk("R10 read sees write", m_rd, 32'hABCD0123); verify("R10 write-read");
    ticks(2);
    op(M_CLR, 1, 0); latch_cnt(); verify("R10 clear-stage");
    chk("R10 staged zero", m_snap, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 6)
        0: set_wd($urandom);
        1: op(16'($urandom) & M_ALL, 1'($urandom), 1'($urandom));
        2: ticks(1 + ($urandom % 4));
        3: latch_cnt();
        4: verify("R5 R7 R10 random");
        default: begin
          wr(A_CTL, 16'($urandom) & M_ALL); repeat (2) @(negedge clk);
          wr(A_CTL, 16'h0); verify("R3 random no pulse");
        end
      endcase
    end
    verify("R9 final");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule